// File: doc/BRIEF.md
# Heartbeat Watchdog Chain Link

This block is one stage in a chain of boards that reports whether every card is present and still active. Each stage is a clocked model of a retriggerable one-shot. It reads the level handed over by the stage before it and a free-running heartbeat from its own local logic. It passes one level on to the next stage. That level is high only while two things hold: the incoming chain level is high, and heartbeat rising edges keep arriving within a fixed window.

When the incoming level drops, the output is forced low. The internal timer is also cleared. When the heartbeat stops, the output falls once the window runs out. In both cases the low travels down every later stage to the combiner at the end of the chain. The first stage in a chain has its input tied high.

The heartbeat is asynchronous, so it is brought in through a synchronizer. Only its rising edges retrigger the timer. The window is a parameter counted in system clock cycles. The default is 100 cycles, which is 1 us at 100 MHz. With that default, any heartbeat faster than 1 MHz keeps the stage alive.

Top module: `hb_chain_link`

## Requirements
- R1: While the synchronous reset is high, and afterwards until the first heartbeat edge is detected, `chain_out` is 0 and the timer holds zero.
- R2: With `chain_in` high, a heartbeat rising edge makes `chain_out` 1 after the third clock edge, counting the first clock edge that samples `hb_in` high as edge one (two synchronizer flops plus one edge-detect flop).
- R3: Each detected heartbeat edge reloads the timer to `TIMEOUT_CYC`. If detected edges are never more than `TIMEOUT_CYC` cycles apart, `chain_out` stays 1 without a gap.
- R4: After the last detected edge, `chain_out` stays 1 for exactly `TIMEOUT_CYC` clock edges and then goes to 0. A heartbeat period of `TIMEOUT_CYC`+1 cycles therefore leaves a one-cycle low gap.
- R5: A 0 on `chain_in` sampled at a clock edge makes `chain_out` 0 after that edge, regardless of the heartbeat. A detected edge in the same cycle is ignored.
- R6: A 0 on `chain_in` also clears the timer. After `chain_in` returns to 1, `chain_out` stays 0 until the next detected heartbeat edge, and it rises on that edge as in R2.
- R7: When two stages are chained, a 0 on the upstream `chain_out` forces the downstream `chain_out` to 0 one clock edge later, even though the downstream heartbeat is running.
- R8: Only rising edges of `hb_in` count. A heartbeat held high gives a single retrigger and then times out as in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| chain_in | input | 1 | Level from the previous stage; 0 clears the stage (first stage: tie to 1) |
| hb_in | input | 1 | Asynchronous heartbeat from local logic |
| chain_out | output | 1 | Level to the next stage; 1 means this stage and every stage before it are alive |

## Verification
The heartbeat path has a fixed latency. A rise on `hb_in` reaches `chain_out` on the third clock edge that samples it. The output then stays high for exactly `TIMEOUT_CYC` edges after the detecting edge, while a low on `chain_in` acts on the very next edge.

The bench drives every input at the falling clock edge and compares both chained stages at the next falling edge. Its model holds a three-deep history of the heartbeat rises it drove, so each rise counts as detected three edges later. It also keeps a countdown that the chain level clears. The expected output is therefore due on the same edge the design must produce it, for every heartbeat period swept on both sides of the window.

// File: rtl/hb_chain_pkg.sv
package hb_chain_pkg;

    typedef enum logic {
        LINK_DOWN = 1'b0,
        LINK_UP   = 1'b1
    } link_e;

    // Bits needed to hold values 0..n
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.sh = (sync_q.sh << 1) | STAGES'(din);
        if (rst) begin
            sync_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        sync_q <= sync_d;
    end

    assign dout = sync_q.sh[STAGES-1];
endmodule

// File: rtl/hb_edge.sv
module hb_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        edge_d.prev = level;
        if (rst) begin
            edge_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        edge_q <= edge_d;
    end

    assign rise = level & ~edge_q.prev;
endmodule

// File: rtl/hb_timer.sv
module hb_timer
    import hb_chain_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic kick,
    output logic alive
);
    localparam int unsigned CW = cnt_bits(TIMEOUT_CYC);
    localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        link_e         st;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!enable) begin
            tmr_d.cnt = '0;                 // active-low clear wins
        end else if (kick) begin
            tmr_d.cnt = RELOAD;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
        tmr_d.st = (tmr_d.cnt != '0) ? LINK_UP : LINK_DOWN;
        if (rst) begin
            tmr_d.cnt = '0;
            tmr_d.st  = LINK_DOWN;
        end
    end

    always_ff @(posedge clk) begin
        tmr_q <= tmr_d;
    end

    assign alive = (tmr_q.st == LINK_UP);
endmodule

// File: rtl/hb_chain_link.sv
module hb_chain_link #(
    parameter int unsigned TIMEOUT_CYC = 100,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic chain_in,
    input  logic hb_in,
    output logic chain_out
);
    logic hb_level;
    logic hb_rise;

    hb_sync #(
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .din (hb_in),
        .dout(hb_level)
    );

    hb_edge edge_i (
        .clk  (clk),
        .rst  (rst),
        .level(hb_level),
        .rise (hb_rise)
    );

    hb_timer #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) timer_i (
        .clk   (clk),
        .rst   (rst),
        .enable(chain_in),
        .kick  (hb_rise),
        .alive (chain_out)
    );
endmodule

// File: rtl/hb_chain_link_chk.sv
module hb_chain_link_chk #(
    parameter int unsigned TIMEOUT_CYC = 100
) (
    input logic clk,
    input logic rst,
    input logic chain_in,
    input logic chain_out,
    input logic hb_edge
);
    localparam int unsigned QW = $clog2(TIMEOUT_CYC + 2) + 1;
    localparam logic [QW-1:0] QSAT = QW'(TIMEOUT_CYC + 1);
    localparam logic [QW-1:0] QLIM = QW'(TIMEOUT_CYC);

    // cycles since the last detected heartbeat edge, saturating
    logic [QW-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst)                  quiet_q <= QSAT;
        else if (hb_edge)         quiet_q <= QW'(1);
        else if (quiet_q != QSAT) quiet_q <= quiet_q + 1'b1;
    end

    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> !chain_out);

    p_edge_raises_r2: assert property (@(posedge clk) disable iff (rst)
        (chain_in && hb_edge) |=> chain_out);

    p_hold_in_window_r3: assert property (@(posedge clk) disable iff (rst)
        (chain_out && chain_in && (quiet_q < QLIM)) |=> chain_out);

    p_fall_after_window_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(chain_out) && $past(chain_in)) |-> (quiet_q == QSAT));

    p_clear_forces_low_r5: assert property (@(posedge clk) disable iff (rst)
        !chain_in |=> !chain_out);
endmodule

bind hb_chain_link hb_chain_link_chk #(
    .TIMEOUT_CYC(TIMEOUT_CYC)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .chain_in (chain_in),
    .chain_out(chain_out),
    .hb_edge  (hb_rise)
);

// File: tb/hb_chain_link_tb_top.sv
`timescale 1ns/1ps
module hb_chain_link_tb_top;
    localparam int T = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chain_in = 1'b1;
    logic hb_a = 1'b0;
    logic hb_b = 1'b0;
    logic out_a, out_b;

    always #2 clk = ~clk;   // 250 MHz

    hb_chain_link #(.TIMEOUT_CYC(T)) dut_i (
        .clk(clk), .rst(rst), .chain_in(chain_in), .hb_in(hb_a), .chain_out(out_a));

    hb_chain_link #(.TIMEOUT_CYC(T)) dn_i (
        .clk(clk), .rst(rst), .chain_in(out_a), .hb_in(hb_b), .chain_out(out_b));

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [2:0] hist_a = '0, hist_b = '0;
    int since_a = 0, since_b = 0;
    logic prev_a = 1'b0, prev_b = 1'b0;

    task automatic step(input logic rs, input logic chin, input logic rise,
                        inout logic [2:0] hist, inout int since);
        if (rs) begin
            hist  = '0;
            since = 0;
        end else begin
            hist = {hist[1:0], rise};
            if (!chin)               since = 0;
            else if (hist[2])        since = 1;
            else if (since != 0 && since <= T) since = since + 1;
        end
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle(input string tag);
        logic ra, rb, ca, cb, rs;
        ra = hb_a & ~prev_a; prev_a = hb_a;
        rb = hb_b & ~prev_b; prev_b = hb_b;
        ca = chain_in;
        cb = out_a;
        rs = rst;
        @(posedge clk);
        @(negedge clk);
        step(rs, ca, ra, hist_a, since_a);
        step(rs, cb, rb, hist_b, since_b);
        check(tag, out_a, (since_a >= 1 && since_a <= T));
        check("R7", out_b, (since_b >= 1 && since_b <= T));
        hb_b = ~hb_b;
    endtask

    // heartbeat of period p (0 = silent) for n cycles
    task automatic run(input int p, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            hb_a = (p != 0) && ((k % p) == 0);
            cycle(tag);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state and idle after reset
        run(0, 4, "R1");
        rst = 1'b0;
        run(0, 6, "R1");
        // R2: first heartbeat raises output after three edges
        run(4, 8, "R2");
        // R3: periods within the window keep the output high
        for (int p = 2; p <= T; p++) run(p, 3 * T, "R3");
        // R4: periods beyond the window leave gaps, then silence times out
        for (int p = T + 1; p <= T + 4; p++) run(p, 4 * p, "R4");
        run(0, T + 6, "R4");
        // R5/R6: clear with running heartbeat, restore with silent heartbeat
        run(2, 10, "R2");
        chain_in = 1'b0;
        run(2, 6, "R5");
        chain_in = 1'b1;
        run(0, 6, "R6");
        run(3, 12, "R6");
        for (int w = 1; w <= 3; w++) begin
            chain_in = 1'b0;
            run(2, w, "R5");
            chain_in = 1'b1;
            run(2, 8, "R6");
        end
        // R8: heartbeat held high gives one retrigger only
        run(2, 8, "R8");
        hb_a = 1'b1;
        for (int k = 0; k < T + 6; k++) cycle("R8");
        run(0, T + 4, "R8");
        // R1: reset in the middle of activity
        run(2, 8, "R3");
        hb_a = 1'b0;
        rst = 1'b1;
        run(0, 4, "R1");
        rst = 1'b0;
        run(0, 5, "R1");
        run(2, 10, "R2");
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule